// File: doc/BRIEF.md
# Stochastic RAM-Neuron Forward Pass Engine

The block computes fresh output bits for a network of 256 probabilistic RAM neurons, one neuron after another, through a single synchronous SRAM read port that it shares for both connection data and weights. For every neuron it first reads six 12-bit connection words. Each word names one binary source: a bit of the network's own output list or a bit of an external input vector. The six selected bits form a 6-bit address that picks one of the neuron's 64 weights. The engine reads that weight and compares it with an 8-bit pseudo-random number. The neuron fires (outputs 1) when the weight is strictly greater.

Each firing result goes out at once on a valid/ready broadcast stream, so that other modules can follow the network. The engine also writes the result into an on-chip output list and keeps the 6-bit address in an on-chip cache, where a later weight-training pass can read it. The output list is double-buffered. Every neuron in a pass therefore sees the outputs of the previous pass, and the new list becomes visible when the pass finishes.

A halt request parks the engine at a neuron boundary, which lets software rewrite the connection table safely. The engine confirms the halt with an acknowledge and makes no SRAM access while it is parked.

Top module: `pram_eval`

## Requirements
- R1: A `start` pulse while idle evaluates neurons 0 to 255 in index order, with exactly one broadcast per neuron. `done` is high for exactly one cycle, in the cycle after the broadcast of neuron 255 is accepted, and `busy` is low from that cycle on.
- R2: For neuron n, the engine reads connection word k (k = 0..5, in increasing k) at SRAM address {1'b1, 3'b000, n[7:0], k[2:0]}. Read data returns on `sram_rdata` one cycle after `sram_re`.
- R3: In a connection word, bit 11 picks the source. A value of 1 selects `ext_in[word[7:0]]`, and a value of 0 selects bit word[7:0] of the previous pass's output list. The bit taken from word k becomes bit k of the neuron's input vector.
- R4: The weight is read at SRAM address {1'b0, n[7:0], vec[5:0]} and taken from `sram_rdata[7:0]`. The output bit is 1 exactly when the weight, read as unsigned, is greater than the current random value.
- R5: The random value comes from an 8-bit shift register. It is loaded with 8'h01 at reset and steps once per evaluated neuron, after that neuron's comparison: next = {r[6:0], r[7]^r[5]^r[4]^r[3]}. It is never reloaded between passes.
- R6: Both output buffers are all zero after reset. Neurons read only the list committed by the previous pass. The newly computed list appears on `out_rd_idx`/`out_rd_bit` from the `done` cycle on.
- R7: After a pass, `vec_rd_data` for index n returns neuron n's input vector from that pass.
- R8: Broadcast stream: `bcast_valid` stays high, with `bcast_bit` and `bcast_idx` held stable, until `bcast_ready` is seen high. No SRAM read is issued while a broadcast waits.
- R9: `halt_req` is honoured when the engine is idle or when a broadcast is accepted. `halt_ack` then rises and stays high until `halt_req` falls. No SRAM read occurs while `halt_ack` is high, and `start` has no effect then. When released mid-pass, the engine continues with the next neuron.
- R10: A `start` pulse while `busy` is high has no effect. The pass still broadcasts each neuron once.
- R11: After reset, `busy`, `done`, `halt_ack`, `bcast_valid` and `sram_re` are all low.

Back-pressure rule: the broadcast stream may be stalled for any number of cycles. The engine simply waits in place with the result held, and it loses or repeats nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (honoured only when idle and not halted) |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| halt_req | input | 1 | Request to park at a neuron boundary |
| halt_ack | output | 1 | Engine is parked |
| ext_in | input | 256 | External input bits, held stable during a pass |
| sram_re | output | 1 | SRAM read strobe |
| sram_addr | output | 15 | SRAM word address |
| sram_rdata | input | 12 | SRAM read data, one cycle after the strobe |
| bcast_valid | output | 1 | Broadcast result valid |
| bcast_ready | input | 1 | Downstream accepts the broadcast |
| bcast_bit | output | 1 | Firing result of the current neuron |
| bcast_idx | output | 8 | Index of the current neuron |
| out_rd_idx | input | 8 | Read index into the committed output list |
| out_rd_bit | output | 1 | Committed output bit at that index |
| vec_rd_idx | input | 8 | Read index into the input-vector cache |
| vec_rd_data | output | 6 | Cached input vector at that index |

## Verification
The case that is hardest to reach from the ports is a neuron whose inputs come from the network's own outputs. Its inputs must reflect the list committed by the previous pass, and never the bits being produced in the current pass. The stimulus table therefore runs passes back to back. It places internally sourced passes after passes that leave a known output pattern, and it shifts the pointer offset so that some neurons read indices that the current pass has already overwritten in the other buffer. A halt raised in the middle of a pass under a toggling ready signal also checks that a parked engine resumes at the correct neuron and keeps the random sequence intact.

// File: rtl/pram_pkg.sv
package pram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_LAST,
    ST_WRD,
    ST_CMP,
    ST_BC,
    ST_HALT
  } seq_state_t;
endpackage

// File: rtl/pram_lfsr.sv
module pram_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] SEED = 1,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] value
);
  logic fb;
  assign fb = ^(value & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= SEED;
    else if (adv) value <= {value[W-2:0], fb};
  end
endmodule

// File: rtl/pram_out_list.sv
module pram_out_list #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_bit,
  input  logic          swap,
  input  logic [IW-1:0] rd_a_idx,
  output logic          rd_a_bit,
  input  logic [IW-1:0] rd_b_idx,
  output logic          rd_b_bit
);
  // Bank 'sel' is committed (read), the other one collects the current pass.
  logic [1:0][N-1:0] bank_q;
  logic              sel_q;
  logic              wsel;

  assign wsel = ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      if (wr_en) bank_q[wsel][wr_idx] <= wr_bit;
      if (swap)  sel_q <= ~sel_q;
    end
  end

  assign rd_a_bit = bank_q[sel_q][rd_a_idx];
  assign rd_b_bit = bank_q[sel_q][rd_b_idx];
endmodule

// File: rtl/pram_vec_cache.sv
module pram_vec_cache #(
  parameter int N  = 256,
  parameter int VW = 6,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [VW-1:0] wr_vec,
  input  logic [IW-1:0] rd_idx,
  output logic [VW-1:0] rd_vec
);
  logic [N-1:0][VW-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mem_q <= '0;
    else if (wr_en) mem_q[wr_idx] <= wr_vec;
  end

  assign rd_vec = mem_q[rd_idx];
endmodule

// File: rtl/pram_eval.sv
module pram_eval #(
  parameter int N_NEURON = 256,
  parameter int N_IN     = 6,
  parameter int PTR_W    = 12,
  parameter int W_W      = 8,
  parameter int IDX_W    = $clog2(N_NEURON),
  parameter int AW       = 1 + IDX_W + N_IN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                busy,
  output logic                done,
  input  logic                halt_req,
  output logic                halt_ack,
  input  logic [N_NEURON-1:0] ext_in,
  output logic                sram_re,
  output logic [AW-1:0]       sram_addr,
  input  logic [PTR_W-1:0]    sram_rdata,
  output logic                bcast_valid,
  input  logic                bcast_ready,
  output logic                bcast_bit,
  output logic [IDX_W-1:0]    bcast_idx,
  input  logic [IDX_W-1:0]    out_rd_idx,
  output logic                out_rd_bit,
  input  logic [IDX_W-1:0]    vec_rd_idx,
  output logic [N_IN-1:0]     vec_rd_data
);
  import pram_pkg::*;

  localparam int K_W   = $clog2(N_IN);
  localparam int PAD_W = AW - 1 - IDX_W - K_W;
  localparam logic [K_W-1:0]   K_LAST = K_W'(N_IN - 1);
  localparam logic [IDX_W-1:0] N_LAST = IDX_W'(N_NEURON - 1);

  seq_state_t       state_q;
  logic [IDX_W-1:0] n_q;
  logic [K_W-1:0]   k_q;
  logic [K_W-1:0]   ptr_k_q;
  logic             ptr_vld_q;
  logic [N_IN-1:0]  vec_q;
  logic             bit_q;
  logic             busy_q;
  logic             done_q;

  logic [W_W-1:0]   rnd;
  logic             fire;
  logic             src_ext;
  logic [IDX_W-1:0] src_idx;
  logic             list_bit;
  logic             src_bit;
  logic             accept;
  logic             last_accept;
  logic             unused_ptr_bits;

  // connection word decode
  assign src_ext         = sram_rdata[PTR_W-1];
  assign src_idx         = sram_rdata[IDX_W-1:0];
  assign src_bit         = src_ext ? ext_in[src_idx] : list_bit;
  assign unused_ptr_bits = ^sram_rdata[PTR_W-2:IDX_W];

  assign fire        = sram_rdata[W_W-1:0] > rnd;
  assign accept      = (state_q == ST_BC) && bcast_ready;
  assign last_accept = accept && (n_q == N_LAST);

  always_comb begin
    sram_re   = 1'b0;
    sram_addr = '0;
    case (state_q)
      ST_PTR: begin
        sram_re   = 1'b1;
        sram_addr = {1'b1, {PAD_W{1'b0}}, n_q, k_q};
      end
      ST_WRD: begin
        sram_re   = 1'b1;
        sram_addr = {1'b0, n_q, vec_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      n_q       <= '0;
      k_q       <= '0;
      ptr_k_q   <= '0;
      ptr_vld_q <= 1'b0;
      vec_q     <= '0;
      bit_q     <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      ptr_vld_q <= (state_q == ST_PTR);
      ptr_k_q   <= k_q;
      if (ptr_vld_q) vec_q[ptr_k_q] <= src_bit;
      case (state_q)
        ST_IDLE: begin
          if (halt_req) begin
            state_q <= ST_HALT;
          end else if (start) begin
            state_q <= ST_PTR;
            busy_q  <= 1'b1;
            n_q     <= '0;
            k_q     <= '0;
          end
        end
        ST_PTR: begin
          if (k_q == K_LAST) state_q <= ST_LAST;
          else               k_q     <= k_q + 1'b1;
        end
        ST_LAST: state_q <= ST_WRD;
        ST_WRD:  state_q <= ST_CMP;
        ST_CMP: begin
          bit_q   <= fire;
          state_q <= ST_BC;
        end
        ST_BC: begin
          if (bcast_ready) begin
            k_q <= '0;
            if (n_q == N_LAST) begin
              done_q  <= 1'b1;
              busy_q  <= 1'b0;
              n_q     <= '0;
              state_q <= halt_req ? ST_HALT : ST_IDLE;
            end else begin
              n_q     <= n_q + 1'b1;
              state_q <= halt_req ? ST_HALT : ST_PTR;
            end
          end
        end
        ST_HALT: begin
          if (!halt_req) state_q <= busy_q ? ST_PTR : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pram_lfsr #(.W(W_W), .SEED(W_W'(1)), .TAPS(W_W'(8'hB8))) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (state_q == ST_CMP),
    .value (rnd)
  );

  pram_out_list #(.N(N_NEURON), .IW(IDX_W)) u_list (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (state_q == ST_CMP),
    .wr_idx   (n_q),
    .wr_bit   (fire),
    .swap     (last_accept),
    .rd_a_idx (src_idx),
    .rd_a_bit (list_bit),
    .rd_b_idx (out_rd_idx),
    .rd_b_bit (out_rd_bit)
  );

  pram_vec_cache #(.N(N_NEURON), .VW(N_IN), .IW(IDX_W)) u_cache (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (state_q == ST_CMP),
    .wr_idx (n_q),
    .wr_vec (vec_q),
    .rd_idx (vec_rd_idx),
    .rd_vec (vec_rd_data)
  );

  assign busy        = busy_q;
  assign done        = done_q;
  assign halt_ack    = (state_q == ST_HALT);
  assign bcast_valid = (state_q == ST_BC);
  assign bcast_bit   = bit_q;
  assign bcast_idx   = n_q;
endmodule

// File: rtl/pram_eval_chk.sv
module pram_eval_chk #(
  parameter int N_NEURON = 256,
  parameter int N_IN     = 6,
  parameter int IDX_W    = 8,
  parameter int AW       = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             busy,
  input logic             halt_req,
  input logic             halt_ack,
  input logic             sram_re,
  input logic [AW-1:0]    sram_addr,
  input logic             bcast_valid,
  input logic             bcast_ready,
  input logic             bcast_bit,
  input logic [IDX_W-1:0] bcast_idx
);
  localparam logic [IDX_W-1:0] N_LAST = IDX_W'(N_NEURON - 1);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(bcast_valid && bcast_ready && bcast_idx == N_LAST)));

  assert_ptr_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_re && sram_addr[AW-1]) |-> (32'(sram_addr[2:0]) < N_IN));

  assert_bc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_valid && !bcast_ready) |=> (bcast_valid && $stable(bcast_bit) && $stable(bcast_idx)));

  assert_no_read_bc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> !sram_re);

  assert_no_read_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ack |-> !sram_re);

  assert_ack_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_ack) |-> $past(halt_req));
endmodule

bind pram_eval pram_eval_chk #(
  .N_NEURON (N_NEURON),
  .N_IN     (N_IN),
  .IDX_W    (IDX_W),
  .AW       (AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done        (done),
  .busy        (busy),
  .halt_req    (halt_req),
  .halt_ack    (halt_ack),
  .sram_re     (sram_re),
  .sram_addr   (sram_addr),
  .bcast_valid (bcast_valid),
  .bcast_ready (bcast_ready),
  .bcast_bit   (bcast_bit),
  .bcast_idx   (bcast_idx)
);

// File: tb/tb_pram_eval.sv
`timescale 1ns/1ps
module tb_pram_eval;
  localparam int N = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         busy, done;
  logic         halt_req = 1'b0;
  logic         halt_ack;
  logic [N-1:0] ext_in = '0;
  logic         sram_re;
  logic [14:0]  sram_addr;
  logic [11:0]  sram_rdata;
  logic         bcast_valid;
  logic         bcast_ready = 1'b1;
  logic         bcast_bit;
  logic [7:0]   bcast_idx;
  logic [7:0]   out_rd_idx = '0;
  logic         out_rd_bit;
  logic [7:0]   vec_rd_idx = '0;
  logic [5:0]   vec_rd_data;

  always #5 clk = ~clk;

  pram_eval dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .halt_req(halt_req), .halt_ack(halt_ack), .ext_in(ext_in),
    .sram_re(sram_re), .sram_addr(sram_addr), .sram_rdata(sram_rdata),
    .bcast_valid(bcast_valid), .bcast_ready(bcast_ready), .bcast_bit(bcast_bit),
    .bcast_idx(bcast_idx), .out_rd_idx(out_rd_idx), .out_rd_bit(out_rd_bit),
    .vec_rd_idx(vec_rd_idx), .vec_rd_data(vec_rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit timeout = 1'b0;

  // pass configuration: {vec5[20:15], has5[14], bp[13], wmode[12:11], off[10:3], pat[2:1], ext[0]}
  localparam int NT = 6;
  localparam logic [20:0] TBL [NT] = '{
    {6'h3F, 1'b1, 1'b0, 2'd0, 8'd0, 2'd1, 1'b1},
    {6'h15, 1'b1, 1'b1, 2'd1, 8'd0, 2'd2, 1'b1},
    {6'h00, 1'b0, 1'b0, 2'd0, 8'd3, 2'd0, 1'b0},
    {6'h00, 1'b1, 1'b1, 2'd3, 8'd0, 2'd0, 1'b1},
    {6'h00, 1'b0, 1'b0, 2'd2, 8'd0, 2'd1, 1'b0},
    {6'h00, 1'b0, 1'b1, 2'd1, 8'd1, 2'd3, 1'b0}
  };

  logic       c_ext;
  logic [7:0] c_off;
  logic [1:0] c_wm;
  logic       c_bp;

  logic [7:0]   lfsr_m = 8'h01;
  logic [N-1:0] prev_m = '0;
  logic [N-1:0] cur_m;
  logic [5:0]   vec_m [N];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] ptr_word(input int n, input int k);
    logic [7:0] idx;
    idx = 8'(n + k + int'(c_off));
    return {c_ext, 3'b000, idx};
  endfunction

  function automatic logic [7:0] wt(input int n, input logic [5:0] v);
    case (c_wm)
      2'd0: return {v, 2'b10};
      2'd1: return {v, 2'b10} ^ 8'(n);
      2'd2: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // synchronous SRAM model with one-cycle latency
  always_ff @(posedge clk) begin
    if (sram_re) begin
      if (sram_addr[14]) sram_rdata <= ptr_word(int'(sram_addr[10:3]), int'(sram_addr[2:0]));
      else               sram_rdata <= {4'h0, wt(int'(sram_addr[13:6]), sram_addr[5:0])};
    end
  end

  function automatic logic [N-1:0] pattern(input logic [1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (p)
        2'd0: r[i] = 1'b0;
        2'd1: r[i] = 1'b1;
        2'd2: r[i] = i[0];
        default: r[i] = i[1];
      endcase
    end
    return r;
  endfunction

  task automatic model_pass();
    for (int n = 0; n < N; n++) begin
      logic [5:0] v;
      for (int k = 0; k < 6; k++) begin
        logic [11:0] p;
        p = ptr_word(n, k);
        v[k] = p[11] ? ext_in[p[7:0]] : prev_m[p[7:0]];
      end
      vec_m[n] = v;
      cur_m[n] = wt(n, v) > lfsr_m;
      lfsr_m = {lfsr_m[6:0], lfsr_m[7] ^ lfsr_m[5] ^ lfsr_m[4] ^ lfsr_m[3]};
    end
  endtask

  task automatic run_pass(input int halt_at, input int restart_at);
    int got = 0;
    int cyc = 0;
    int hc = 0;
    int hbad = 0;
    int ord_bad = 0;
    int bit_bad = 0;
    model_pass();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (got < N && !timeout) begin
      @(negedge clk);
      cyc++;
      bcast_ready = c_bp ? cyc[0] : 1'b1;
      start = (cyc == restart_at);
      if (cyc == halt_at) halt_req = 1'b1;
      if (halt_req && halt_ack) begin
        hc++;
        if (sram_re || bcast_valid) hbad++;
        if (hc == 20) halt_req = 1'b0;
      end
      #1;
      if (bcast_valid && bcast_ready) begin
        if (int'(bcast_idx) != got) begin
          ord_bad++;
          if (ord_bad == 1) check(1'b0, "R1", "broadcast order", int'(bcast_idx), got);
        end
        if (bcast_bit != cur_m[got]) begin
          bit_bad++;
          if (bit_bad == 1) check(1'b0, "R4", "firing bit", int'(bcast_bit), int'(cur_m[got]));
        end
        got++;
      end
    end
    start = 1'b0;
    check(ord_bad == 0 && got == N, "R1", "broadcast count", got, N);
    check(bit_bad == 0, "R5", "firing bits vs random sequence", bit_bad, 0);
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R1", "done after last", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0, "R1", "done single cycle", int'(done), 0);
    bcast_ready = 1'b1;
    if (halt_at >= 0) begin
      check(hc >= 20, "R9", "halt acknowledged", hc, 20);
      check(hbad == 0, "R9", "no access while halted", hbad, 0);
    end
    if (restart_at >= 0) check(ord_bad == 0, "R10", "restart ignored", ord_bad, 0);
    begin
      int lb = 0;
      int vb = 0;
      for (int i = 0; i < N; i++) begin
        out_rd_idx = 8'(i);
        vec_rd_idx = 8'(i);
        #1;
        if (out_rd_bit !== cur_m[i]) lb++;
        if (vec_rd_data !== vec_m[i]) vb++;
      end
      check(lb == 0, "R6", "committed list mismatches", lb, 0);
      check(vb == 0, "R7", "cached vector mismatches", vb, 0);
      check(vb == 0, "R3", "decoded inputs", vb, 0);
    end
    prev_m = cur_m;
  endtask

  initial begin
    #(200000 * 10);
    timeout = 1'b1;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    c_ext = 1'b0; c_off = '0; c_wm = '0; c_bp = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(busy === 1'b0 && done === 1'b0, "R11", "busy/done at reset", int'(busy) + int'(done), 0);
    check(halt_ack === 1'b0 && bcast_valid === 1'b0 && sram_re === 1'b0, "R11",
          "ack/valid/read at reset", int'(halt_ack) + int'(bcast_valid) + int'(sram_re), 0);
    rst_n = 1'b1;
    @(negedge clk);
    out_rd_idx = 8'd77; #1;
    check(out_rd_bit === 1'b0, "R6", "list zero after reset", int'(out_rd_bit), 0);

    // table of pass configurations
    for (int t = 0; t < NT; t++) begin
      logic [20:0] e;
      e = TBL[t];
      c_ext = e[0];
      ext_in = pattern(e[2:1]);
      c_off = e[10:3];
      c_wm = e[12:11];
      c_bp = e[13];
      run_pass(-1, -1);
      if (e[14]) begin
        vec_rd_idx = 8'd5; #1;
        check(vec_rd_data === e[20:15], "R7", "table vector of neuron 5",
              int'(vec_rd_data), int'(e[20:15]));
      end
      if (timeout) break;
    end

    // R9 halt while idle: start ignored, no access
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); @(negedge clk);
    check(halt_ack === 1'b1, "R9", "ack when idle", int'(halt_ack), 1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && sram_re === 1'b0, "R9", "start ignored while halted", int'(busy), 0);
    halt_req = 1'b0;
    @(negedge clk); @(negedge clk);
    check(halt_ack === 1'b0 && busy === 1'b0, "R9", "release to idle", int'(halt_ack), 0);

    // R9 halt mid-pass with back-pressure, R10 restart while busy, internal sources (R3, R6)
    c_ext = 1'b0; c_off = 8'd2; c_wm = 2'd1; c_bp = 1'b1;
    run_pass(700, 40);
    c_ext = 1'b1; ext_in = pattern(2'd3); c_off = 8'd9; c_wm = 2'd0; c_bp = 1'b0;
    run_pass(1300, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule